// File: doc/BRIEF.md
# Encrypted Region Access Checker

This block watches the access stream going into an on-the-fly decrypting memory path. Each access is compared against up to four address windows. For each access the block decides whether the data returned to the requester must be replaced with zeros. It also records three kinds of error in sticky flags. The decryption datapath itself lives elsewhere. It uses the zero verdict from this block to mask its read data.

The window settings are plain input vectors, one slice per window: an enable bit, a 2-bit mode, inclusive low and high bounds, and the current 8-bit key checksum. A global encryption-mode bit applies to all windows. Accesses arrive as a single-cycle strobe. There is no back-pressure: every strobed access is accepted in the cycle it is presented. Its verdict appears on the response pins exactly one clock later.

Software sees three small registers through a one-cycle write strobe and a combinational read port: error status, write-one-to-clear, and interrupt enable. These combine into one interrupt line.

Top module: `enc_region_guard`

## Requirements
- R1: `rsp_valid_o` is high in the cycle after a cycle with `acc_valid_i` high, and low otherwise. When `rsp_valid_o` is low, `rsp_hit_o`, `rsp_region_o` and `rsp_zero_o` are 0.
- R2: An access hits window i when that window is enabled and low <= address <= high, with both bounds included. Where windows overlap, the lowest index wins, and `rsp_region_o` carries that index. A miss reports hit 0 and region 0, and is not zeroed except under R6.
- R3: An access, either a fetch or a data read, that hits a window whose key checksum is 8'h00 is zeroed and sets the key-error flag (status bit 2).
- R4: After a key error on a window, that window keeps zeroing accesses until a clock edge is seen with its checksum nonzero. An access in the first cycle with a nonzero checksum is therefore still zeroed. Clearing the flag does not lift the block.
- R5: A data read (`acc_fetch_i` = 0) that hits a window with mode 2'b11 is zeroed and sets the execute-only flag (status bit 1). A fetch to that window is served.
- R6: While `enc_mode_i` = 1, every fetch is zeroed and sets status bit 1, whether or not it hits. Data reads are not affected by this bit.
- R7: `sec_err_i` high at a clock edge sets the security flag (status bit 0).
- R8: Flags are sticky. Writing 1 to a bit of the clear register (`csr_sel_i` = 1) clears that flag, and a set event in the same cycle wins over the clear. Select 0 reads the status, and writes to it are ignored. Select 1 and select 3 read 0. Select 2 is the interrupt-enable register, which can be read and written and uses the same bit layout.
- R9: `irq_o` is the OR, over the three bits, of each flag ANDed with its enable bit.
- R10: Reset clears all flags, enables and key blocks, and `rsp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_mode_i | input | 1 | Global encryption mode: fetches are refused |
| sec_err_i | input | 1 | Security error event |
| acc_valid_i | input | 1 | Access strobe |
| acc_fetch_i | input | 1 | 1 = instruction fetch, 0 = data read |
| acc_addr_i | input | ADDR_W | Access address |
| rgn_en_i | input | NREG | Per-window enable |
| rgn_mode_i | input | 2*NREG | Per-window mode, window i at [2i+1:2i] |
| rgn_crc_i | input | 8*NREG | Per-window key checksum |
| rgn_lo_i | input | ADDR_W*NREG | Per-window inclusive low bound |
| rgn_hi_i | input | ADDR_W*NREG | Per-window inclusive high bound |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | Register select: 0 status, 1 clear, 2 enable |
| csr_wdata_i | input | 3 | Register write data |
| csr_rdata_o | output | 3 | Register read data for the current select |
| rsp_valid_o | output | 1 | Verdict valid |
| rsp_hit_o | output | 1 | Access hit a window |
| rsp_region_o | output | IDX_W | Winning window index |
| rsp_zero_o | output | 1 | Returned data must be zeroed |
| irq_o | output | 1 | Interrupt |

## Verification
The windows are set so that two of them overlap, one has a zero checksum and one is disabled. The addresses used sit just inside and just outside every bound. This separates inclusive from exclusive comparison and lowest-index from highest-index priority. Fetches and data reads go to the execute-only window, with encryption mode both off and on, to show which causes zero the data and which raise a flag. A checksum repair that lands in the same cycle as an access exposes the one-edge lag of the key block. Clear writes that coincide with set events show that the set wins. A long random phase then mixes all of these inputs.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int FLAG_W = 3;
  localparam int BIT_SEC = 0;
  localparam int BIT_XO  = 1;
  localparam int BIT_KEY = 2;
  localparam logic [1:0] MODE_XONLY = 2'b11;

  typedef enum logic [1:0] {
    CSR_STATUS = 2'd0,
    CSR_CLEAR  = 2'd1,
    CSR_ENABLE = 2'd2,
    CSR_NONE   = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/guard_region_match.sv
module guard_region_match #(
  parameter int NREG   = 4,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NREG-1:0]        en_i,
  input  logic [ADDR_W*NREG-1:0] lo_i,
  input  logic [ADDR_W*NREG-1:0] hi_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [NREG-1:0] in_rng;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign in_rng[g] = en_i[g]
                     && (addr_i >= lo_i[g*ADDR_W +: ADDR_W])
                     && (addr_i <= hi_i[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    hit_o = |in_rng;
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (in_rng[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/guard_flags.sv
module guard_flags
  import guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_sel_i,
  input  logic [FLAG_W-1:0] csr_wdata_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] csr_rdata_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q, ien_q, clr;
  csr_sel_e sel;

  assign sel = csr_sel_e'(csr_sel_i);
  assign clr = (csr_we_i && sel == CSR_CLEAR) ? csr_wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ien_q   <= '0;
    end else begin
      flags_q <= (flags_q & ~clr) | set_i;
      if (csr_we_i && sel == CSR_ENABLE) ien_q <= csr_wdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      CSR_STATUS: csr_rdata_o = flags_q;
      CSR_ENABLE: csr_rdata_o = ien_q;
      default:    csr_rdata_o = '0;
    endcase
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & ien_q);
endmodule

// File: rtl/enc_region_guard.sv
module enc_region_guard
  import guard_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enc_mode_i,
  input  logic                   sec_err_i,
  input  logic                   acc_valid_i,
  input  logic                   acc_fetch_i,
  input  logic [ADDR_W-1:0]      acc_addr_i,
  input  logic [NREG-1:0]        rgn_en_i,
  input  logic [2*NREG-1:0]      rgn_mode_i,
  input  logic [8*NREG-1:0]      rgn_crc_i,
  input  logic [ADDR_W*NREG-1:0] rgn_lo_i,
  input  logic [ADDR_W*NREG-1:0] rgn_hi_i,
  input  logic                   csr_we_i,
  input  logic [1:0]             csr_sel_i,
  input  logic [2:0]             csr_wdata_i,
  output logic [2:0]             csr_rdata_o,
  output logic                   rsp_valid_o,
  output logic                   rsp_hit_o,
  output logic [IDX_W-1:0]       rsp_region_o,
  output logic                   rsp_zero_o,
  output logic                   irq_o
);
  logic [7:0]        crc_a  [NREG];
  logic [1:0]        mode_a [NREG];
  logic [NREG-1:0]   blk_q;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              key_bad, xo_rd, enc_fx, zero;
  logic [FLAG_W-1:0] set, flags;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign crc_a[g]  = rgn_crc_i[g*8 +: 8];
    assign mode_a[g] = rgn_mode_i[g*2 +: 2];
  end

  guard_region_match #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .addr_i(acc_addr_i), .en_i(rgn_en_i), .lo_i(rgn_lo_i), .hi_i(rgn_hi_i),
    .hit_o(hit), .idx_o(idx)
  );

  assign key_bad = hit && (crc_a[idx] == 8'h00);
  assign xo_rd   = hit && (mode_a[idx] == MODE_XONLY) && !acc_fetch_i;
  assign enc_fx  = enc_mode_i && acc_fetch_i;
  assign zero    = enc_fx || xo_rd || key_bad || (hit && blk_q[idx]);

  always_comb begin
    set          = '0;
    set[BIT_SEC] = sec_err_i;
    set[BIT_XO]  = acc_valid_i && (xo_rd || enc_fx);
    set[BIT_KEY] = acc_valid_i && key_bad;
  end

  // per-window key block: held until a nonzero checksum is seen at an edge
  for (genvar g = 0; g < NREG; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     blk_q[g] <= 1'b0;
      else if (crc_a[g] != 8'h00)     blk_q[g] <= 1'b0;
      else if (acc_valid_i && key_bad && idx == IDX_W'(g)) blk_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_region_o <= '0;
      rsp_zero_o   <= 1'b0;
    end else begin
      rsp_valid_o  <= acc_valid_i;
      rsp_hit_o    <= acc_valid_i && hit;
      rsp_region_o <= (acc_valid_i && hit) ? idx : '0;
      rsp_zero_o   <= acc_valid_i && zero;
    end
  end

  guard_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set),
    .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
    .flags_o(flags), .csr_rdata_o(csr_rdata_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/guard_chk.sv
module guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enc_mode_i,
  input logic       sec_err_i,
  input logic       acc_valid_i,
  input logic       acc_fetch_i,
  input logic       csr_we_i,
  input logic [1:0] csr_sel_i,
  input logic [2:0] csr_wdata_i,
  input logic [2:0] csr_rdata_o,
  input logic [2:0] flags,
  input logic       rsp_valid_o,
  input logic       rsp_hit_o,
  input logic       rsp_zero_o,
  input logic       irq_o
);
  logic [2:0] clr_req;
  assign clr_req = (csr_we_i && csr_sel_i == 2'd1) ? csr_wdata_i : 3'b000;

  AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_i |=> rsp_valid_o); // R1
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !rsp_valid_o && !rsp_zero_o); // R1
  AST_MISS_NOT_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !(enc_mode_i && acc_fetch_i)) ##1 (rsp_valid_o && !rsp_hit_o) |-> !rsp_zero_o); // R2
  AST_ENC_FETCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_fetch_i && enc_mode_i) |=> rsp_zero_o && flags[1]); // R6
  AST_SEC_PIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_err_i |=> flags[0]); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~clr_req) != 3'b000 |=> ($past(flags & ~clr_req) & ~flags) == 3'b000); // R8
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_sel_i == 2'd1 |-> csr_rdata_o == 3'b000); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flags != 3'b000); // R9
endmodule

bind enc_region_guard guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enc_mode_i(enc_mode_i), .sec_err_i(sec_err_i),
  .acc_valid_i(acc_valid_i), .acc_fetch_i(acc_fetch_i),
  .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
  .csr_rdata_o(csr_rdata_o), .flags(flags),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_zero_o(rsp_zero_o),
  .irq_o(irq_o)
);

// File: tb/enc_region_guard_bench.sv
`timescale 1ns/1ps
module enc_region_guard_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, enc, sec, av, fetch, we;
  logic [31:0] addr;
  logic [1:0] sel;
  logic [2:0] wdata, rdata;
  logic rv, rhit, rzero, irq;
  logic [1:0] rreg;
  logic [31:0] lo [4];
  logic [31:0] hi [4];
  logic [7:0]  crc [4];
  logic [1:0]  md [4];
  logic [3:0]  en;
  logic [127:0] lo_v, hi_v;
  logic [31:0] crc_v;
  logic [7:0]  md_v;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      lo_v[i*32 +: 32] = lo[i];
      hi_v[i*32 +: 32] = hi[i];
      crc_v[i*8 +: 8]  = crc[i];
      md_v[i*2 +: 2]   = md[i];
    end
  end

  enc_region_guard u_enc_region_guard (
    .clk(clk), .rst_n(rst_n), .enc_mode_i(enc), .sec_err_i(sec),
    .acc_valid_i(av), .acc_fetch_i(fetch), .acc_addr_i(addr),
    .rgn_en_i(en), .rgn_mode_i(md_v), .rgn_crc_i(crc_v),
    .rgn_lo_i(lo_v), .rgn_hi_i(hi_v),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .rsp_valid_o(rv), .rsp_hit_o(rhit), .rsp_region_o(rreg),
    .rsp_zero_o(rzero), .irq_o(irq)
  );

  int vectors = 0, errors = 0;
  logic [2:0] m_flags, m_ien;
  logic [3:0] m_blk;
  logic m_rv, m_hit, m_zero;
  logic [1:0] m_reg;
  string m_tag;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find_hit(input logic [31:0] a);
    for (int i = 0; i < 4; i++)
      if (en[i] && a >= lo[i] && a <= hi[i]) return i;
    return -1;
  endfunction

  task automatic step();
    int h;
    logic kb, xo, ef, z;
    logic [2:0] setv, clrv, n_flags, n_ien;
    logic [3:0] n_blk;
    #1;
    // R8 register read port reflects current state
    if (sel == 2'd0)      chk("R3 R5 R6 R7 R8 status read", rdata, m_flags);
    else if (sel == 2'd2) chk("R8 enable read", rdata, m_ien);
    else                  chk("R8 clear/unused reads zero", rdata, 0);
    h  = find_hit(addr);
    kb = (h >= 0) && crc[h] == 8'h00;
    xo = (h >= 0) && md[h] == 2'b11 && !fetch;
    ef = enc && fetch;
    z  = ef || xo || kb || ((h >= 0) && m_blk[h]);
    setv = {av && kb, av && (xo || ef), sec};
    clrv = (we && sel == 2'd1) ? wdata : 3'b000;
    n_flags = (m_flags & ~clrv) | setv;
    n_ien   = (we && sel == 2'd2) ? wdata : m_ien;
    for (int i = 0; i < 4; i++)
      n_blk[i] = (crc[i] != 8'h00) ? 1'b0 : (m_blk[i] | (av && kb && h == i));
    if (ef)                              m_tag = "R6";
    else if (xo)                         m_tag = "R5";
    else if (kb)                         m_tag = "R3";
    else if ((h >= 0) && m_blk[h])       m_tag = "R4";
    else                                 m_tag = "R2";
    @(posedge clk);
    m_flags = n_flags; m_ien = n_ien; m_blk = n_blk;
    m_rv = av; m_hit = av && h >= 0; m_reg = m_hit ? 2'(h) : 2'd0; m_zero = av && z;
    @(negedge clk);
    chk("R1 rsp_valid", rv, m_rv);
    chk("R2 rsp_hit", rhit, m_hit);
    chk("R2 rsp_region", rreg, m_reg);
    chk({m_tag, " rsp_zero"}, rzero, m_zero);
    chk("R9 irq", irq, |(m_flags & m_ien));
    av = 0; we = 0; sec = 0; sel = 2'd0;
  endtask

  task automatic access(input logic f, input logic [31:0] a);
    av = 1; fetch = f; addr = a; step();
  endtask

  task automatic csr_write(input logic [1:0] s, input logic [2:0] d);
    we = 1; sel = s; wdata = d; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 0; enc = 0; sec = 0; av = 0; fetch = 0; we = 0;
    addr = 0; sel = 0; wdata = 0;
    lo[0] = 32'h1000; hi[0] = 32'h1FFF; crc[0] = 8'h5A; md[0] = 2'b00;
    lo[1] = 32'h1800; hi[1] = 32'h27FF; crc[1] = 8'h33; md[1] = 2'b11;
    lo[2] = 32'h3000; hi[2] = 32'h3FFF; crc[2] = 8'h00; md[2] = 2'b00;
    lo[3] = 32'h5000; hi[3] = 32'h5FFF; crc[3] = 8'h77; md[3] = 2'b00;
    en = 4'b0111;
    m_flags = 0; m_ien = 0; m_blk = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10 rsp_valid in reset", rv, 0);
    chk("R10 status in reset", rdata, 0);
    chk("R10 irq in reset", irq, 0);
    rst_n = 1;
    sel = 2'd2; step();
    csr_write(2'd2, 3'b111);
    // R2 bounds and priority
    access(0, 32'h0FFF); access(0, 32'h1000); access(0, 32'h1FFF);
    access(1, 32'h1800); access(1, 32'h2000); access(1, 32'h27FF);
    access(0, 32'h2800); access(0, 32'h5000);
    // R5 execute-only window: data read refused
    access(0, 32'h2000);
    csr_write(2'd1, 3'b010);
    // R3 key error
    access(0, 32'h3000);
    csr_write(2'd1, 3'b100);
    // R4 still blocked after clear
    access(1, 32'h3FFF);
    crc[2] = 8'h11; access(0, 32'h3004);
    access(0, 32'h3008);
    // R6 encryption mode
    enc = 1; access(1, 32'h0000); access(0, 32'h1000); access(1, 32'h1004); enc = 0;
    // R7 security pin, R8 set wins over clear
    sec = 1; step();
    sec = 1; csr_write(2'd1, 3'b001);
    csr_write(2'd0, 3'b000);
    csr_write(2'd1, 3'b111);
    csr_write(2'd3, 3'b111);
    sel = 2'd3; step();
    csr_write(2'd2, 3'b001);
    sec = 1; step();
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] picks [8];
      picks[0] = 32'h0FFF; picks[1] = 32'h1000; picks[2] = 32'h1FFF; picks[3] = 32'h2000;
      picks[4] = 32'h27FF; picks[5] = 32'h3000; picks[6] = 32'h3FFF; picks[7] = 32'h5800;
      av = $urandom_range(0, 3) != 0;
      fetch = $urandom_range(0, 1);
      addr = picks[$urandom_range(0, 7)];
      enc = $urandom_range(0, 7) == 0;
      sec = $urandom_range(0, 15) == 0;
      we = $urandom_range(0, 3) == 0;
      sel = 2'($urandom_range(0, 3));
      wdata = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) crc[2] = crc[2] == 0 ? 8'h11 : 8'h00;
      if ($urandom_range(0, 19) == 0) crc[0] = crc[0] == 0 ? 8'h5A : 8'h00;
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule